// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Power-Up Hold-Off

This block collects interrupt requests for a USB On-The-Go bridge and presents them to a host processor as one interrupt line. It has a 32-bit top-level source register and two lower-level groups: a 32-bit endpoint group and a 32-bit DMA completion group. Each group and the top level can be set, cleared and masked through a small 32-bit register bus. The lower-level groups fold into three summary bits of the top-level register. The endpoint group gives a transmit summary for its low half-word and a receive summary for its high half-word. The DMA group gives one completion summary.

The output line has a programmable sense. In active-high sense it is raised when some unmasked top-level source is pending. In the other sense it is raised only while nothing unmasked is pending. When power is applied, a ready flag is cleared and the line is held low. The flag rises again only after a hold-off of `HOLD_CYC` clock cycles. Hardware event inputs set and clear top-level bits directly, and they win over a software write to the same bit in the same cycle.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, every source register reads 0, every mask register reads 0xFFFFFFFF, the configuration register reads 0 and `irq_out` is low.
- R2: Registers decode at fixed offsets of `bus_addr`. Configuration is at 0x83C. The endpoint group uses 0x840/0x844/0x848/0x84C for source/set/clear/mask, the DMA group uses 0x850..0x85C in the same order, and the top level uses 0x870..0x87C in the same order. Any other offset reads 0, and a write to it changes nothing.
- R3: A write to a set offset ORs `bus_wdata` into that source register. Reading the source, set or clear offset of a group returns the group's current source value.
- R4: A write to a clear offset clears the source bits where `bus_wdata` is 1. A write to a mask offset replaces the mask. A mask bit of 1 hides the matching source bit.
- R5: Top-level bit 9 reads 1 exactly when some bit in 15:0 of the endpoint source is 1 with its mask bit 0. Top-level bit 8 does the same for bits 31:16.
- R6: Top-level bit 24 reads 1 exactly when some DMA source bit is 1 with its mask bit 0.
- R7: Top-level bits 8, 9 and 24 follow only the group summaries. Top-level set and clear writes and hardware events on those bits have no effect.
- R8: Bit 17 of the configuration register selects the sense. When it is 1, `irq_out` = ready AND (some unmasked top-level bit is pending). When it is 0, `irq_out` = ready AND (no unmasked top-level bit is pending).
- R9: In the cycle after `pwr_on` rises, ready is low. Ready goes high `HOLD_CYC` clock edges after the edge that saw the rise, provided `pwr_on` stays high. Until then `irq_out` is low.
- R10: Dropping `pwr_on` cancels a hold-off that is still running, and ready is left unchanged. A later rise of `pwr_on` starts a full new hold-off.
- R11: On each clock edge, `hw_set` bits force top-level bits to 1 and `hw_clr` bits force them to 0, overriding a software set or clear of the same bit. When `hw_set` and `hw_clr` are both 1 for a bit, set wins.
- R12: The effect of any register write shows on `bus_rdata` and `irq_out` right after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the clock edge |
| bus_addr | input | 12 | Register offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwr_on | input | 1 | Power-applied level |
| hw_set | input | 32 | Per-bit level set events for the top-level source |
| hw_clr | input | 32 | Per-bit level clear events for the top-level source |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The hardest case to reach is the interaction of the hold-off with a power drop. Power must fall after the count has started but before it ends, and the line must then stay low for good until a new full count completes. The stimulus raises `pwr_on`, drops it part way through a short `HOLD_CYC`, idles well past the original expiry, then raises it again and watches the exact edge at which the line comes back. A second hard case is a hardware event and a software write hitting the same top-level bit in one cycle. The stimulus lines these up on purpose for set-versus-clear and for clear-versus-set. A reference model compares every read and the line on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 12'h83C;
  localparam logic [ADDR_W-1:0] OFS_EP   = 12'h840;
  localparam logic [ADDR_W-1:0] OFS_DMA  = 12'h850;
  localparam logic [ADDR_W-1:0] OFS_TOP  = 12'h870;

  localparam int unsigned POS_RX  = 8;
  localparam int unsigned POS_TX  = 9;
  localparam int unsigned POS_DMA = 24;
  localparam int unsigned POS_POL = 17;

  localparam logic [DATA_W-1:0] SUM_POS =
    (DATA_W'(1) << POS_RX) | (DATA_W'(1) << POS_TX) | (DATA_W'(1) << POS_DMA);

  typedef enum logic [1:0] {OP_NONE, OP_SET, OP_CLR, OP_MASK} grp_op_e;

  function automatic grp_op_e decode_op(logic wr, logic [ADDR_W-1:0] a,
                                        logic [ADDR_W-1:0] base);
    if (!wr)                          return OP_NONE;
    if (a == base + ADDR_W'(4))       return OP_SET;
    if (a == base + ADDR_W'(8))       return OP_CLR;
    if (a == base + ADDR_W'(12))      return OP_MASK;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/irq_agg_group.sv
module irq_agg_group
  import irq_agg_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  grp_op_e      op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ev_set,
  input  logic [W-1:0] ev_clr,
  output logic [W-1:0] src,
  output logic [W-1:0] mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] src_n, mask_n, sw_val;
  logic         src_en, mask_en;

  always_comb begin
    unique case (op)
      OP_SET:  sw_val = src | wdata;
      OP_CLR:  sw_val = src & ~wdata;
      default: sw_val = src;
    endcase
    src_n   = ((sw_val | ev_set) & ~(ev_clr & ~ev_set)) & KEEP;
    src_en  = (src_n != src);
    mask_n  = wdata;
    mask_en = (op == OP_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src  <= '0;
      mask <= '1;
    end else begin
      if (src_en)  src  <= src_n;
      if (mask_en) mask <= mask_n;
    end
  end

  assign pend = src & ~mask;
endmodule

// File: rtl/irq_agg_holdoff.sv
module irq_agg_holdoff #(
  parameter int unsigned HOLD_CYC = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic ready
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt, cnt_n;
  logic          pwr_q, rdy_n;

  always_comb begin
    cnt_n = cnt;
    rdy_n = ready;
    if (pwr_on && !pwr_q) begin
      cnt_n = CW'(HOLD_CYC);
      rdy_n = 1'b0;
    end else if (!pwr_on) begin
      cnt_n = '0;
    end else if (cnt == CW'(1)) begin
      cnt_n = '0;
      rdy_n = 1'b1;
    end else if (cnt != '0) begin
      cnt_n = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
      pwr_q <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      ready <= rdy_n;
      pwr_q <= pwr_on;
    end
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 30_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_on,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_clr,
  output logic              irq_out
);
  localparam int unsigned HALF = DATA_W / 2;

  grp_op_e           ep_op, dma_op, top_op;
  logic [DATA_W-1:0] ep_src, ep_mask, ep_pend;
  logic [DATA_W-1:0] dma_src, dma_mask, dma_pend;
  logic [DATA_W-1:0] top_stored, top_mask, top_pend_raw;
  logic [DATA_W-1:0] flags, cfg, cfg_n;
  logic              cfg_en, ready, any_pend;

  always_comb begin
    ep_op  = decode_op(bus_wr, bus_addr, OFS_EP);
    dma_op = decode_op(bus_wr, bus_addr, OFS_DMA);
    top_op = decode_op(bus_wr, bus_addr, OFS_TOP);
    cfg_en = bus_wr && (bus_addr == OFS_CFG);
    cfg_n  = bus_wdata;
  end

  irq_agg_group #(.W(DATA_W), .KEEP('1)) u_ep (
    .clk(clk), .rst_n(rst_n), .op(ep_op), .wdata(bus_wdata),
    .ev_set('0), .ev_clr('0),
    .src(ep_src), .mask(ep_mask), .pend(ep_pend)
  );

  irq_agg_group #(.W(DATA_W), .KEEP('1)) u_dma (
    .clk(clk), .rst_n(rst_n), .op(dma_op), .wdata(bus_wdata),
    .ev_set('0), .ev_clr('0),
    .src(dma_src), .mask(dma_mask), .pend(dma_pend)
  );

  irq_agg_group #(.W(DATA_W), .KEEP(~SUM_POS)) u_top (
    .clk(clk), .rst_n(rst_n), .op(top_op), .wdata(bus_wdata),
    .ev_set(hw_set), .ev_clr(hw_clr),
    .src(top_stored), .mask(top_mask), .pend(top_pend_raw)
  );

  irq_agg_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .ready(ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (cfg_en) cfg <= cfg_n;
  end

  always_comb begin
    flags = top_stored;
    flags[POS_TX]  = |ep_pend[HALF-1:0];
    flags[POS_RX]  = |ep_pend[DATA_W-1:HALF];
    flags[POS_DMA] = |dma_pend;
    any_pend = |(flags & ~top_mask);
    irq_out  = ready & (cfg[POS_POL] ? any_pend : ~any_pend);
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CFG:                               bus_rdata = cfg;
      OFS_EP,  OFS_EP + 12'h4,  OFS_EP + 12'h8:  bus_rdata = ep_src;
      OFS_EP + 12'hC:                        bus_rdata = ep_mask;
      OFS_DMA, OFS_DMA + 12'h4, OFS_DMA + 12'h8: bus_rdata = dma_src;
      OFS_DMA + 12'hC:                       bus_rdata = dma_mask;
      OFS_TOP, OFS_TOP + 12'h4, OFS_TOP + 12'h8: bus_rdata = flags;
      OFS_TOP + 12'hC:                       bus_rdata = top_mask;
      default:                               bus_rdata = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^top_pend_raw;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              pwr_on,
  input logic [DATA_W-1:0] hw_set,
  input logic [DATA_W-1:0] ep_src,
  input logic [DATA_W-1:0] ep_mask,
  input logic [DATA_W-1:0] dma_src,
  input logic [DATA_W-1:0] top_stored,
  input logic [DATA_W-1:0] flags,
  input logic              ready,
  input logic              irq_out
);
  localparam logic [DATA_W-1:0] KEEP = ~SUM_POS;

  a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EP + 12'h4) |=>
      ((ep_src & $past(bus_wdata)) == $past(bus_wdata)));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DMA + 12'h8) |=>
      ((dma_src & $past(bus_wdata)) == '0));

  a_r5_tx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EP + 12'h4 &&
     |(bus_wdata[15:0] & ~ep_mask[15:0])) |=> flags[POS_TX]);

  a_r6_dma_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DMA + 12'hC && |(dma_src & ~bus_wdata))
      |=> flags[POS_DMA]);

  a_r9_holdoff_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |=> !ready);

  a_r9_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !irq_out);

  a_r10_no_rise_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on && !ready) |=> !ready);

  a_r11_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & KEEP)) |=>
      ((top_stored & $past(hw_set & KEEP)) == $past(hw_set & KEEP)));
endmodule

bind irq_agg_top irq_agg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pwr_on(pwr_on), .hw_set(hw_set),
  .ep_src(ep_src), .ep_mask(ep_mask), .dma_src(dma_src),
  .top_stored(top_stored), .flags(flags), .ready(ready), .irq_out(irq_out)
);

// File: tb/irq_agg_top_test.sv
`timescale 1ns/1ps
module irq_agg_top_test;
  localparam int HOLD = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_on = 1'b0;
  logic [31:0] hw_set = '0;
  logic [31:0] hw_clr = '0;
  logic        irq_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_agg_top #(.HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_on(pwr_on),
    .hw_set(hw_set), .hw_clr(hw_clr), .irq_out(irq_out)
  );

  // Reference model state
  logic [31:0] m_cfg, m_eps, m_epm, m_dms, m_dmm, m_tps, m_tpm;
  int          m_cnt;
  bit          m_rdy, m_pwr;

  function automatic logic [31:0] m_flags();
    logic [31:0] f;
    f = m_tps;
    f[9]  = (m_eps[15:0] & ~m_epm[15:0]) != 0;
    f[8]  = (m_eps[31:16] & ~m_epm[31:16]) != 0;
    f[24] = (m_dms & ~m_dmm) != 0;
    return f;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h83C: return m_cfg;
      12'h840, 12'h844, 12'h848: return m_eps;
      12'h84C: return m_epm;
      12'h850, 12'h854, 12'h858: return m_dms;
      12'h85C: return m_dmm;
      12'h870, 12'h874, 12'h878: return m_flags();
      12'h87C: return m_tpm;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit m_irq();
    bit p;
    p = (m_flags() & ~m_tpm) != 0;
    return m_rdy && (m_cfg[17] ? p : !p);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_eps = 0; m_dms = 0; m_tps = 0;
      m_epm = '1; m_dmm = '1; m_tpm = '1;
      m_cnt = 0; m_rdy = 0; m_pwr = 0;
    end else begin
      logic [31:0] t;
      t = m_tps;
      if (bus_wr) begin
        case (bus_addr)
          12'h83C: m_cfg = bus_wdata;
          12'h844: m_eps = m_eps | bus_wdata;
          12'h848: m_eps = m_eps & ~bus_wdata;
          12'h84C: m_epm = bus_wdata;
          12'h854: m_dms = m_dms | bus_wdata;
          12'h858: m_dms = m_dms & ~bus_wdata;
          12'h85C: m_dmm = bus_wdata;
          12'h874: t = t | bus_wdata;
          12'h878: t = t & ~bus_wdata;
          12'h87C: m_tpm = bus_wdata;
          default: ;
        endcase
      end
      for (int b = 0; b < 32; b++) begin
        if (hw_set[b]) t[b] = 1'b1;
        else if (hw_clr[b]) t[b] = 1'b0;
      end
      t[8] = 0; t[9] = 0; t[24] = 0;
      m_tps = t;
      if (pwr_on && !m_pwr) begin m_cnt = HOLD; m_rdy = 0; end
      else if (!pwr_on) m_cnt = 0;
      else if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_rdy = 1;
      end
      m_pwr = pwr_on;
    end
  end

  task automatic step(input logic [11:0] a, input logic w, input logic [31:0] d,
                      input string tag);
    logic [31:0] er;
    bit          ei;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    #1;
    er = m_read(a);
    ei = m_irq();
    vectors++;
    if (bus_rdata !== er) begin
      errors++;
      $display("FAIL %s rdata @%h: actual %h expected %h", tag, a, bus_rdata, er);
    end
    if (irq_out !== ei) begin
      errors++;
      $display("FAIL %s irq_out: actual %b expected %b", tag, irq_out, ei);
    end
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(a, 1'b0, 32'h0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(a, 1'b1, d, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    rd(12'h870, "R1"); rd(12'h87C, "R1"); rd(12'h840, "R1"); rd(12'h84C, "R1");
    rd(12'h850, "R1"); rd(12'h85C, "R1"); rd(12'h83C, "R1");
    // R2 unknown offset reads zero, write ignored
    wr(12'h804, 32'hFFFF_FFFF, "R2"); rd(12'h804, "R2"); rd(12'h87C, "R2");
    rd(12'h83C, "R2");
    // R9 power-up hold-off, sense 0 with nothing pending -> line high when ready
    pwr_on = 1'b1;
    for (int i = 0; i < HOLD + 3; i++) rd(12'h870, "R9");
    // R8 active-high sense, nothing pending -> low
    wr(12'h83C, 32'h0002_0000, "R8"); rd(12'h83C, "R8");
    // R3 set, read through set and clear offsets
    wr(12'h844, 32'h0001_0003, "R3"); rd(12'h844, "R3"); rd(12'h848, "R3");
    // R4 / R5 / R12 masks expose summaries
    wr(12'h84C, 32'hFFFF_FFFE, "R5"); rd(12'h870, "R5");
    wr(12'h87C, ~(32'h1 << 9), "R12"); rd(12'h870, "R12");
    wr(12'h848, 32'h0000_0001, "R4"); rd(12'h870, "R5");
    wr(12'h84C, 32'h0, "R5"); rd(12'h870, "R5");
    wr(12'h87C, ~(32'h1 << 8), "R5"); rd(12'h870, "R5");
    wr(12'h848, 32'h0001_0000, "R5"); rd(12'h870, "R5");
    // R6 DMA summary
    wr(12'h854, 32'h0000_0080, "R6"); rd(12'h870, "R6");
    wr(12'h85C, 32'hFFFF_FF7F, "R6"); rd(12'h870, "R6");
    wr(12'h87C, ~(32'h1 << 24), "R6"); rd(12'h870, "R6");
    wr(12'h858, 32'h0000_0080, "R6"); rd(12'h850, "R6"); rd(12'h870, "R6");
    // R7 summary positions not writable
    wr(12'h874, 32'hFFFF_FFFF, "R7"); rd(12'h870, "R7");
    wr(12'h878, 32'h0000_0F0F, "R7"); rd(12'h878, "R7");
    hw_set = 32'h0100_0300; rd(12'h870, "R7");
    hw_set = 32'h0; rd(12'h870, "R7");
    // R11 hardware priority over software
    hw_set = 32'h0000_0008; wr(12'h878, 32'h0000_0008, "R11");
    hw_set = 32'h0; rd(12'h870, "R11");
    hw_clr = 32'h0000_0010; wr(12'h874, 32'h0000_0010, "R11");
    hw_clr = 32'h0; rd(12'h870, "R11");
    hw_set = 32'h0000_0020; hw_clr = 32'h0000_0020; wr(12'h878, 32'h20, "R11");
    hw_set = 32'h0; hw_clr = 32'h0; rd(12'h870, "R11");
    // R8 sense flips with pending sources
    wr(12'h87C, 32'h0, "R8"); rd(12'h870, "R8");
    wr(12'h83C, 32'h0, "R8"); rd(12'h870, "R8");
    wr(12'h878, 32'hFFFF_FFFF, "R8"); rd(12'h870, "R8");
    wr(12'h83C, 32'h0002_0000, "R8"); rd(12'h870, "R8");
    wr(12'h874, 32'h4000_0000, "R8"); rd(12'h870, "R8");
    // R10 power drop mid hold-off
    pwr_on = 1'b0; rd(12'h870, "R10");
    pwr_on = 1'b1; rd(12'h870, "R10");
    for (int i = 0; i < HOLD / 2; i++) rd(12'h870, "R10");
    pwr_on = 1'b0;
    for (int i = 0; i < HOLD * 2; i++) rd(12'h870, "R10");
    pwr_on = 1'b1;
    for (int i = 0; i < HOLD + 3; i++) rd(12'h870, "R9");
    rd(12'h87C, "R4"); rd(12'h84C, "R4"); rd(12'h85C, "R4");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule